// File: doc/BRIEF.md
# Banked Extended-Register Window

This block is a device-side register file that sits behind a simple synchronous register bus. Thirty-two directly addressed 16-bit locations are visible on the bus. Three of them form an access window into larger extended register banks, and the rest are plain storage.

Software reaches an extended register in two steps. For a write, it first loads the data word into the write-data holding register. It then writes a command word into the window control register. The command word carries a read strobe, a write strobe, a bank number and an offset. For a read, it writes a command word with the read strobe set. The addressed word is then waiting in the read-data holding register, and the very next bus read can return it.

Bank 0 is the direct register space. Banks 1 to 3 are private internal arrays. Banks 4 to 7 are legal bank numbers but have no storage behind them.

Top module: `ext_reg_window`

## Requirements
- R1: A synchronous active-high reset clears every location, including the control, read-data and write-data holding registers. After reset, every direct address reads 0x0000.
- R2: Every direct address except 0x14, 0x15 and 0x16 is a plain 16-bit read/write location. These locations make up bank 0.
- R3: A bus write to 0x16 loads the write-data holding register, and reading 0x16 returns it. The read-data holding register at 0x15 is read-only, so bus writes to 0x15 change nothing.
- R4: A bus write to 0x14 stores the full 16-bit command word, and reading 0x14 returns that word unchanged.
- R5: A command word with bit 11 set and bit 12 clear copies the write-data holding register into the extended register selected by bits [10:8] (the bank) and bits [7:0] (the offset). The copy happens at the same clock edge that stores the command word.
- R6: A command word with bit 12 set and bit 11 clear loads the selected extended register into 0x15 at the same clock edge, so a bus read of 0x15 in the next cycle returns the new value.
- R7: A command word with both bit 11 and bit 12 set, or with neither set, only stores the command word. The read-data holding register and all bank contents stay unchanged.
- R8: Through the window, bank 0 reaches the direct locations at offsets below 0x20. Offsets 0x14 to 0x16 and offsets of 0x20 and above read as zero and ignore writes.
- R9: Banks 1, 2 and 3 are independent 32-entry arrays. In these banks, offsets of 0x20 and above read as zero and ignore writes.
- R10: Banks 4 to 7 always read as zero, and writes to them are ignored.
- R11: Bus read data is combinational from the current address while the read strobe is high, and it is 0x0000 while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Direct register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_re is high |

## Verification
The bench uses the default parameters: a 5-bit address, three extended banks and 32 entries per bank. With these values, every direct address can be visited exhaustively. The bench also uses them to probe offsets just inside and just past the 32-entry depth, and to reach the unimplemented banks 4 to 7 through the 3-bit bank field. Because the bank depth is small, a few hundred random commands revisit the same locations often, so the bench can detect writes that land in the wrong bank or at the wrong offset.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  localparam int WORD_W = 16;
  localparam int BANK_W = 3;
  localparam int OFFS_W = 8;

  // Direct indices of the window registers (decoded by software)
  localparam int CTRL_IDX   = 20;
  localparam int RDHOLD_IDX = 21;
  localparam int WRHOLD_IDX = 22;

  // Command strobe positions inside the control word
  localparam int RD_BIT = 12;
  localparam int WR_BIT = 11;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } win_cmd_e;

  typedef struct packed {
    win_cmd_e             cmd;
    logic [BANK_W-1:0]    bank;
    logic [OFFS_W-1:0]    offs;
  } win_req_t;

  function automatic win_req_t unpack_ctrl(input logic [WORD_W-1:0] w);
    win_req_t r;
    logic rd;
    logic wr;
    rd = w[RD_BIT];
    wr = w[WR_BIT];
    if (rd && !wr)      r.cmd = CMD_READ;
    else if (wr && !rd) r.cmd = CMD_WRITE;
    else                r.cmd = CMD_NONE;
    r.bank = w[OFFS_W+BANK_W-1:OFFS_W];
    r.offs = w[OFFS_W-1:0];
    return r;
  endfunction

  function automatic logic is_window_idx(input int unsigned idx);
    return (idx >= CTRL_IDX) && (idx <= WRHOLD_IDX);
  endfunction

endpackage

// File: rtl/win_cmd_decode.sv
module win_cmd_decode
  import winreg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              ctrl_wr,
  output logic              xfer_rd,
  output logic              xfer_wr,
  output logic [BANK_W-1:0] xfer_bank,
  output logic [OFFS_W-1:0] xfer_offs
);

  win_req_t req;

  always_comb begin
    req       = unpack_ctrl(bus_wdata);
    ctrl_wr   = bus_we && (bus_addr == ADDR_W'(CTRL_IDX));
    xfer_rd   = ctrl_wr && (req.cmd == CMD_READ);
    xfer_wr   = ctrl_wr && (req.cmd == CMD_WRITE);
    xfer_bank = req.bank;
    xfer_offs = req.offs;
  end

endmodule

// File: rtl/win_bank_store.sv
module win_bank_store
  import winreg_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [OFFS_W-1:0] offs,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign hit   = (int'(offs) < DEPTH);
  assign idx   = IDX_W'(offs);
  assign rdata = hit ? mem_q[idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we && hit) begin
      mem_q[idx] <= wdata;
    end
  end

endmodule

// File: rtl/ext_reg_window.sv
module ext_reg_window
  import winreg_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int NUM_EXT_BANKS = 3,
  parameter int EXT_DEPTH     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);

  localparam int DIRECT_DEPTH = 2 ** ADDR_W;

  // Named internal events, visible to the bound checker
  logic              ctrl_wr;
  logic              xfer_rd;
  logic              xfer_wr;
  logic [BANK_W-1:0] xfer_bank;
  logic [OFFS_W-1:0] xfer_offs;

  logic [WORD_W-1:0] ctrl_q;
  logic [WORD_W-1:0] rd_hold;
  logic [WORD_W-1:0] wr_hold;
  logic [WORD_W-1:0] dir_q [DIRECT_DEPTH];

  logic              bank0_hit;
  logic [WORD_W-1:0] ext_rd_val;
  logic [WORD_W-1:0] bank_rd [NUM_EXT_BANKS];

  win_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_wr   (ctrl_wr),
    .xfer_rd   (xfer_rd),
    .xfer_wr   (xfer_wr),
    .xfer_bank (xfer_bank),
    .xfer_offs (xfer_offs)
  );

  // Banks 1..NUM_EXT_BANKS: private arrays
  for (genvar g = 0; g < NUM_EXT_BANKS; g++) begin : g_bank
    win_bank_store #(.DEPTH(EXT_DEPTH)) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (xfer_wr && (xfer_bank == BANK_W'(g + 1))),
      .offs  (xfer_offs),
      .wdata (wr_hold),
      .rdata (bank_rd[g])
    );
  end

  // Bank 0 maps onto direct storage, minus the window itself
  assign bank0_hit = (int'(xfer_offs) < DIRECT_DEPTH) &&
                     !is_window_idx(int'(xfer_offs));

  always_comb begin
    ext_rd_val = '0;
    if (xfer_bank == '0) begin
      if (bank0_hit) ext_rd_val = dir_q[ADDR_W'(xfer_offs)];
    end else begin
      for (int g = 0; g < NUM_EXT_BANKS; g++) begin
        if (xfer_bank == BANK_W'(g + 1)) ext_rd_val = bank_rd[g];
      end
    end
  end

  // Direct storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DIRECT_DEPTH; i++) dir_q[i] <= '0;
    end else begin
      if (bus_we && !is_window_idx(int'(bus_addr))) begin
        dir_q[bus_addr] <= bus_wdata;
      end
      if (xfer_wr && (xfer_bank == '0) && bank0_hit) begin
        dir_q[ADDR_W'(xfer_offs)] <= wr_hold;
      end
    end
  end

  // Window registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rd_hold <= '0;
      wr_hold <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata;
      if (xfer_rd) rd_hold <= ext_rd_val;
      if (bus_we && (bus_addr == ADDR_W'(WRHOLD_IDX))) wr_hold <= bus_wdata;
    end
  end

  // Combinational bus read
  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == ADDR_W'(CTRL_IDX))        bus_rdata = ctrl_q;
      else if (bus_addr == ADDR_W'(RDHOLD_IDX)) bus_rdata = rd_hold;
      else if (bus_addr == ADDR_W'(WRHOLD_IDX)) bus_rdata = wr_hold;
      else                                      bus_rdata = dir_q[bus_addr];
    end
  end

endmodule

// File: rtl/win_checks.sv
module win_checks
  import winreg_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int NUM_EXT_BANKS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              xfer_rd,
  input logic              xfer_wr,
  input logic [BANK_W-1:0] xfer_bank,
  input logic [WORD_W-1:0] ctrl_q,
  input logic [WORD_W-1:0] rd_hold,
  input logic [WORD_W-1:0] wr_hold
);

  // R7: never a read and a write transfer together
  p_cmd_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(xfer_rd && xfer_wr));

  // R4: control word captured whole
  p_ctrl_store_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(CTRL_IDX)) |=> (ctrl_q == $past(bus_wdata)));

  // R3: write-data holding register loads from the bus
  p_wrhold_load_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(WRHOLD_IDX)) |=> (wr_hold == $past(bus_wdata)));

  // R3: bus writes do not reach the read-data holding register
  p_rdhold_ro_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(RDHOLD_IDX)) |=> $stable(rd_hold));

  // R7: read-data holding register changes only on a read transfer
  p_rdhold_keep_r7: assert property (@(posedge clk) disable iff (rst)
    !xfer_rd |=> $stable(rd_hold));

  // R10: unimplemented banks read as zero
  p_far_bank_r10: assert property (@(posedge clk) disable iff (rst)
    (xfer_rd && int'(xfer_bank) > NUM_EXT_BANKS) |=> (rd_hold == '0));

  // R11: idle read bus is zero
  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_re |-> (bus_rdata == '0));

endmodule

bind ext_reg_window win_checks #(
  .ADDR_W        (ADDR_W),
  .NUM_EXT_BANKS (NUM_EXT_BANKS)
) u_win_checks (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .xfer_rd   (xfer_rd),
  .xfer_wr   (xfer_wr),
  .xfer_bank (xfer_bank),
  .ctrl_q    (ctrl_q),
  .rd_hold   (rd_hold),
  .wr_hold   (wr_hold)
);

// File: tb/tb_ext_reg_window.sv
`timescale 1ns/1ps
module tb_ext_reg_window;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we  = 1'b0;
  logic        re  = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wd  = '0;
  logic [15:0] rd;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model state
  logic [15:0] mdl [8][256];
  logic [15:0] ctrl_m, rdh_m, wrh_m;

  always #2.5 clk = ~clk;

  ext_reg_window dut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rd)
  );

  function automatic bit loc_ok(int b, int o);
    if (b == 0) return (o < 32) && !(o >= 20 && o <= 22);
    if (b >= 1 && b <= 3) return o < 32;
    return 0;
  endfunction

  function automatic logic [15:0] model_read(int a);
    if (a == 20) return ctrl_m;
    if (a == 21) return rdh_m;
    if (a == 22) return wrh_m;
    return mdl[0][a];
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 8; b++)
      for (int o = 0; o < 256; o++) mdl[b][o] = 16'h0;
    ctrl_m = 0; rdh_m = 0; wrh_m = 0;
  endtask

  task automatic model_update(logic w, int a, logic [15:0] d);
    int b, o;
    if (!w) return;
    if (a == 20) begin
      ctrl_m = d;
      b = int'(d[10:8]);
      o = int'(d[7:0]);
      if (d[12] && !d[11]) rdh_m = loc_ok(b, o) ? mdl[b][o] : 16'h0;
      else if (d[11] && !d[12] && loc_ok(b, o)) mdl[b][o] = wrh_m;
    end else if (a == 22) begin
      wrh_m = d;
    end else if (a != 21) begin
      mdl[0][a] = d;
    end
  endtask

  task automatic step(logic w, logic r, int a, logic [15:0] d, string tag);
    logic [15:0] expv;
    @(negedge clk);
    we = w; re = r; addr = 5'(a); wd = d;
    #1;
    expv = r ? model_read(a) : 16'h0;
    n_chk++;
    if (rd !== expv) begin
      n_fail++;
      $display("FAIL %s: addr %02h got %04h expected %04h", tag, a, rd, expv);
    end
    @(posedge clk);
    model_update(w, a, d);
  endtask

  function automatic logic [15:0] cmd(bit r, bit w, int b, int o);
    return {3'b000, r, w, 3'(b), 8'(o)};
  endfunction

  task automatic ext_wr(int b, int o, logic [15:0] d, string tag);
    step(1, 0, 22, d, tag);
    step(1, 0, 20, cmd(0, 1, b, o), tag);
  endtask

  task automatic ext_rd(int b, int o, string tag);
    step(1, 0, 20, cmd(1, 0, b, o), tag);
    step(0, 1, 21, 16'h0, tag);   // back-to-back read of read-data holding
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: all direct addresses read zero after reset
    for (int a = 0; a < 32; a++) step(0, 1, a, 0, "R1 reset value");
    // R11: idle read strobe gives zero
    step(0, 0, 3, 0, "R11 idle rdata");

    // R2: plain storage, R3: holding registers
    for (int a = 0; a < 32; a++) if (a != 20) step(1, 0, a, 16'(16'h1100 + a * 16'h0107), "R2 fill");
    for (int a = 0; a < 32; a++) step(0, 1, a, 0, "R2 R3 readback");
    step(1, 0, 21, 16'hDEAD, "R3 write to read-only");
    step(0, 1, 21, 0, "R3 read-only holding");

    // R4: full control word readback (no transfer, both bits set)
    step(1, 0, 20, 16'hFFFF, "R4 ctrl store");
    step(0, 1, 20, 0, "R4 ctrl readback");

    // R5 R6: write and read back through window in bank 1
    ext_wr(1, 5, 16'hA5A5, "R5 bank1 write");
    ext_rd(1, 5, "R6 bank1 read");

    // R9: bank separation and depth edge
    ext_wr(2, 5, 16'h1234, "R9 bank2 write");
    ext_wr(3, 5, 16'h5678, "R9 bank3 write");
    ext_rd(1, 5, "R9 bank1 intact");
    ext_rd(2, 5, "R9 bank2");
    ext_rd(3, 5, "R9 bank3");
    ext_wr(3, 31, 16'h0F0F, "R9 last entry write");
    ext_rd(3, 31, "R9 last entry");
    ext_wr(1, 32, 16'hBEEF, "R9 past depth write");
    ext_rd(1, 32, "R9 past depth zero");
    ext_rd(1, 0, "R9 entry0 untouched");

    // R10: banks 4..7
    for (int b = 4; b < 8; b++) begin
      ext_wr(b, 2, 16'hCAFE, "R10 far bank write");
      ext_rd(b, 2, "R10 far bank zero");
    end

    // R8: bank 0 aliasing
    ext_wr(0, 3, 16'h7777, "R8 bank0 write");
    step(0, 1, 3, 0, "R8 direct sees bank0");
    ext_rd(0, 9, "R8 bank0 read");
    ext_rd(0, 20, "R8 window offset zero");
    ext_wr(0, 22, 16'h4444, "R8 window offset ignored");
    step(0, 1, 22, 0, "R8 wr hold intact");
    ext_rd(0, 40, "R8 bank0 past depth zero");

    // R7: both and neither strobes
    ext_rd(2, 5, "R7 prime");
    step(1, 0, 22, 16'h9999, "R7 load");
    step(1, 0, 20, cmd(1, 1, 2, 5), "R7 both bits");
    step(0, 1, 21, 0, "R7 rd hold unchanged");
    step(1, 0, 20, cmd(0, 0, 2, 5), "R7 neither bit");
    step(0, 1, 21, 0, "R7 rd hold unchanged 2");
    ext_rd(2, 5, "R7 target unchanged");

    // Random mix covering R2..R11
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom_range(0, 5));
      case (k)
        0: step(1, 0, int'($urandom_range(0, 31)), 16'($urandom), "R2 rnd write");
        1: step(0, 1, int'($urandom_range(0, 31)), 0, "R2 rnd read");
        2: step(1, 0, 22, 16'($urandom), "R3 rnd hold");
        3: step(1, 0, 20, cmd(1'($urandom), 1'($urandom), int'($urandom_range(0, 7)),
                              int'($urandom_range(0, 40))), "R5 rnd ctrl");
        4: step(0, 1, 21, 0, "R6 rnd rdhold");
        default: step(0, 0, int'($urandom_range(0, 31)), 0, "R11 rnd idle");
      endcase
    end

    finish_run();
  end

endmodule